// File: doc/BRIEF.md
# DMA Source Address Stepper

This block holds the source address of one DMA channel and moves it after every completed transfer unit. A 2-bit mode selects one of three behaviours: the address stays put, it counts up, or it counts down. A 2-bit unit-size code sets how far it moves. Software-side control logic writes a start address through the load port. The transfer engine then pulses a done strobe once per unit it finishes.

Some settings are illegal: the reserved mode value, and counting down with 16-byte units. When a done strobe arrives with an illegal setting, the address is held and a sticky error flag is raised. In single address mode with the data coming from an external device that uses an acknowledge handshake, no source address is driven on the bus. In that case the mode and size inputs are ignored and the address never changes.

Top module: `dma_src_addr_stepper`

## Requirements
- R1: A cycle with `rst` high leaves `addr_o` at 0 and `err_o` at 0 after that clock edge.
- R2: With `load_i` high, `addr_o` equals `load_addr_i` after the next edge. This applies even if `done_i` is high in the same cycle, and such a cycle never sets the error flag.
- R3: Mode 2'b00 (fixed): a done strobe leaves `addr_o` unchanged.
- R4: Mode 2'b01 (increment): a done strobe adds 1, 2, 4 or 16 for unit codes 2'b00 (byte), 2'b01 (word), 2'b10 (longword) and 2'b11 (16-byte).
- R5: Mode 2'b10 (decrement): a done strobe subtracts 1, 2 or 4 for unit codes 2'b00, 2'b01 and 2'b10.
- R6: Mode 2'b11 with a done strobe sets `err_o` and holds `addr_o`.
- R7: Mode 2'b10 with unit code 2'b11 and a done strobe sets `err_o` and holds `addr_o`.
- R8: When `single_i`=1 and `ack_src_i`=1, a done strobe leaves `addr_o` and `err_o` unchanged, whatever the mode and unit inputs are, including illegal ones.
- R9: `err_o` stays high until reset; loads and later legal steps do not clear it.
- R10: The address wraps modulo 2^32 in both directions.
- R11: With neither `done_i` nor `load_i` high, `addr_o` holds.
- R12: In dual address mode (`single_i`=0), `ack_src_i` has no effect and steps happen normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Source address mode: 00 fixed, 01 up, 10 down, 11 illegal |
| unit_i | input | 2 | Unit size: 00 byte, 01 word, 10 longword, 11 16-byte |
| single_i | input | 1 | 1 = single address mode, 0 = dual |
| ack_src_i | input | 1 | Data source is an external device with acknowledge handshake |
| load_i | input | 1 | Load start address |
| load_addr_i | input | 32 | Start address value |
| done_i | input | 1 | One transfer unit completed |
| addr_o | output | 32 | Current source address (registered) |
| err_o | output | 1 | Sticky illegal-setting flag (registered) |

## Verification
The assertions assume that `mode_i`, `unit_i`, `single_i` and `ack_src_i` are valid whenever `done_i` or `load_i` is high. They place no restriction on how the strobes are combined: load and done may be high in the same cycle, and done may be high on consecutive cycles. The stimulus changes every input only on the falling edge. It deliberately includes illegal settings, the acknowledge-device bypass together with an illegal mode, and load and done in the same cycle. It also drives steps across the top and bottom of the address space.

// File: rtl/dma_src_pkg.sv
package dma_src_pkg;
  typedef enum logic [1:0] {
    SRC_FIXED = 2'b00,
    SRC_UP    = 2'b01,
    SRC_DOWN  = 2'b10,
    SRC_RSVD  = 2'b11
  } src_mode_e;

  typedef enum logic [1:0] {
    UNIT_B8   = 2'b00,
    UNIT_B16  = 2'b01,
    UNIT_B32  = 2'b10,
    UNIT_B128 = 2'b11
  } unit_e;

  // log2 of the byte count moved per unit
  function automatic logic [2:0] unit_shift(input unit_e u);
    case (u)
      UNIT_B8:   unit_shift = 3'd0;
      UNIT_B16:  unit_shift = 3'd1;
      UNIT_B32:  unit_shift = 3'd2;
      default:   unit_shift = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_src_step_dec.sv
module dma_src_step_dec
  import dma_src_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        mode,
  input  logic [1:0]        unit,
  input  logic              single,
  input  logic              ack_src,
  output logic [ADDR_W-1:0] delta,
  output logic              bypass,
  output logic              illegal
);
  localparam int SH_W = 3;

  logic [ADDR_W-1:0] mag;
  logic [SH_W-1:0]   sh;
  src_mode_e         m;
  unit_e             u;

  assign m  = src_mode_e'(mode);
  assign u  = unit_e'(unit);
  assign sh = unit_shift(u);
  assign mag = {{(ADDR_W-1){1'b0}}, 1'b1} << sh;

  // no source address is driven for an acknowledge-device source in single mode
  assign bypass = single & ack_src;

  always_comb begin
    delta   = '0;
    illegal = 1'b0;
    case (m)
      SRC_FIXED: delta = '0;
      SRC_UP:    delta = mag;
      SRC_DOWN: begin
        if (u == UNIT_B128) illegal = 1'b1;
        else                delta   = ~mag + 1'b1;
      end
      default:   illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/dma_src_addr_reg.sv
module dma_src_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic [ADDR_W-1:0] delta,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + delta;
  end
endmodule

// File: rtl/dma_src_err_flag.sv
module dma_src_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/dma_src_addr_stepper.sv
module dma_src_addr_stepper #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        unit_i,
  input  logic              single_i,
  input  logic              ack_src_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              done_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              err_o
);
  logic [ADDR_W-1:0] delta;
  logic              bypass;
  logic              illegal;
  logic              live;

  dma_src_step_dec #(.ADDR_W(ADDR_W)) u_dec (
    .mode    (mode_i),
    .unit    (unit_i),
    .single  (single_i),
    .ack_src (ack_src_i),
    .delta   (delta),
    .bypass  (bypass),
    .illegal (illegal)
  );

  // a done strobe that is not overridden by a load and not bypassed
  assign live = done_i & ~load_i & ~bypass;

  dma_src_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (load_i),
    .load_val (load_addr_i),
    .step     (live & ~illegal),
    .delta    (delta),
    .addr     (addr_o)
  );

  dma_src_err_flag u_err (
    .clk  (clk),
    .rst  (rst),
    .set  (live & illegal),
    .flag (err_o)
  );
endmodule

// File: rtl/dma_src_addr_stepper_chk.sv
module dma_src_addr_stepper_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode_i,
  input logic [1:0]        unit_i,
  input logic              single_i,
  input logic              ack_src_i,
  input logic              load_i,
  input logic [ADDR_W-1:0] load_addr_i,
  input logic              done_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              err_o
);
  function automatic logic [ADDR_W-1:0] sz(input logic [1:0] u);
    case (u)
      2'b00:   sz = ADDR_W'(1);
      2'b01:   sz = ADDR_W'(2);
      2'b10:   sz = ADDR_W'(4);
      default: sz = ADDR_W'(16);
    endcase
  endfunction

  logic act;
  assign act = done_i && !load_i && !(single_i && ack_src_i);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (addr_o == '0 && !err_o));
  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_o == $past(load_addr_i) && err_o == $past(err_o)));
  // R3
  fixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (act && mode_i == 2'b00) |=> $stable(addr_o));
  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (act && mode_i == 2'b01) |=> addr_o == $past(addr_o) + sz($past(unit_i)));
  // R5
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (act && mode_i == 2'b10 && unit_i != 2'b11) |=> addr_o == $past(addr_o) - sz($past(unit_i)));
  // R6
  rsvd_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (act && mode_i == 2'b11) |=> (err_o && $stable(addr_o)));
  // R7
  down_wide_chk: assert property (@(posedge clk) disable iff (rst)
    (act && mode_i == 2'b10 && unit_i == 2'b11) |=> (err_o && $stable(addr_o)));
  // R8
  ack_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && !load_i && single_i && ack_src_i) |=> ($stable(addr_o) && $stable(err_o)));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err_o |=> err_o);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done_i && !load_i) |=> $stable(addr_o));
endmodule

bind dma_src_addr_stepper dma_src_addr_stepper_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_src_addr_stepper_tb.sv
module dma_src_addr_stepper_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = '0, unit_i = '0;
  logic        single_i = 1'b0, ack_src_i = 1'b0, load_i = 1'b0, done_i = 1'b0;
  logic [31:0] load_addr_i = '0;
  logic [31:0] addr_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_addr = '0;
  logic        m_err = 1'b0;

  always #2 clk = ~clk;

  dma_src_addr_stepper u_dut (.*);

  // behavioural reference, one call per clock
  task automatic cyc(input string tag, input bit r, input bit ld, input logic [31:0] la,
                     input bit dn, input logic [1:0] m, input logic [1:0] u,
                     input bit sg, input bit ak);
    int stepb;
    @(negedge clk);
    rst = r; load_i = ld; load_addr_i = la; done_i = dn;
    mode_i = m; unit_i = u; single_i = sg; ack_src_i = ak;
    @(posedge clk);
    stepb = (u == 2'd3) ? 16 : (1 << u);
    if (r) begin
      m_addr = 0; m_err = 0;
    end else if (ld) begin
      m_addr = la;
    end else if (dn && !(sg && ak)) begin
      if (m == 2'd3 || (m == 2'd2 && u == 2'd3)) m_err = 1;
      else if (m == 2'd1) m_addr = m_addr + 32'(stepb);
      else if (m == 2'd2) m_addr = m_addr - 32'(stepb);
    end
    #1;
    checks++;
    if (addr_o !== m_addr || err_o !== m_err) begin
      errors++;
      $display("FAIL %s: addr=%h err=%b expected addr=%h err=%b", tag, addr_o, err_o, m_addr, m_err);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc("R1 reset", 1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1 reset", 1, 0, 0, 1, 1, 0, 0, 0);
    cyc("R2 load", 0, 1, 32'h0000_1000, 0, 0, 0, 0, 0);
    for (int u = 0; u < 4; u++) cyc("R4 up", 0, 0, 0, 1, 2'd1, 2'(u), 0, 0);
    for (int u = 0; u < 3; u++) cyc("R5 down", 0, 0, 0, 1, 2'd2, 2'(u), 0, 0);
    cyc("R3 fixed", 0, 0, 0, 1, 2'd0, 2'd2, 0, 0);
    cyc("R3 fixed", 0, 0, 0, 1, 2'd0, 2'd3, 1, 0);
    cyc("R11 idle", 0, 0, 0, 0, 2'd1, 2'd2, 0, 0);
    cyc("R11 idle", 0, 0, 0, 0, 2'd2, 2'd0, 0, 0);
    cyc("R12 dual ack", 0, 0, 0, 1, 2'd1, 2'd1, 0, 1);
    cyc("R12 dual ack", 0, 0, 0, 1, 2'd2, 2'd0, 0, 1);
    cyc("R8 bypass up", 0, 0, 0, 1, 2'd1, 2'd3, 1, 1);
    cyc("R8 bypass rsvd", 0, 0, 0, 1, 2'd3, 2'd0, 1, 1);
    cyc("R8 bypass down16", 0, 0, 0, 1, 2'd2, 2'd3, 1, 1);
    cyc("R10 load top", 0, 1, 32'hFFFF_FFFE, 0, 0, 0, 0, 0);
    cyc("R10 wrap up", 0, 0, 0, 1, 2'd1, 2'd2, 0, 0);
    cyc("R10 load low", 0, 1, 32'h0000_0001, 0, 0, 0, 0, 0);
    cyc("R10 wrap down", 0, 0, 0, 1, 2'd2, 2'd1, 0, 0);
    cyc("R2 load beats done", 0, 1, 32'h0000_0040, 1, 2'd1, 2'd3, 0, 0);
    cyc("R2 load beats illegal", 0, 1, 32'h0000_0080, 1, 2'd3, 2'd0, 0, 0);
    cyc("R6 rsvd mode", 0, 0, 0, 1, 2'd3, 2'd1, 0, 0);
    cyc("R9 sticky after load", 0, 1, 32'h0000_0200, 0, 0, 0, 0, 0);
    cyc("R9 sticky after step", 0, 0, 0, 1, 2'd1, 2'd0, 0, 0);
    cyc("R1 reset clears err", 1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R2 load", 0, 1, 32'h0000_0300, 0, 0, 0, 0, 0);
    cyc("R7 down 16", 0, 0, 0, 1, 2'd2, 2'd3, 0, 0);
    cyc("R9 sticky idle", 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 40; k++)
      cyc("R4 R5 mix", 0, (k % 13) == 0, 32'(k * 977), (k % 3) != 0,
          2'(k % 4 == 3 ? 1 : k % 3), 2'(k % 4), k[3], k[2]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule